// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block keeps two 16-bit address pointers for moves to and from external data memory, which spans the full 64 kB space. At any moment only one pointer, picked by a select bit in a control register, drives the address output. Software reaches both pointers, byte by byte, and the control register through a small register port with a combinational read path.

Two optional behaviours save instructions in block copies. With auto-update on, each completed pointer-based move steps the active pointer up or down by one. Each pointer has its own direction bit. With toggle on, each move flips the select bit, so source and destination pointers alternate without any software action. A separate increment strobe always adds one to the active pointer and never flips the select bit. The instruction decoder and the memory bus that issue these strobes sit outside the block.

Top module: `dptr_pair_unit`

## Requirements
- R1: After reset, both pointers, every control bit and `addr_out` are zero.
- R2: Register map at `reg_addr`: 0 is pointer A low byte, 1 is pointer A high byte, 2 is pointer B low byte, 3 is pointer B high byte, 4 is control. A write updates only the addressed byte. `reg_rdata` returns the addressed register in the same cycle. Control bits 1, 6 and 7 read as zero. Addresses 5 to 7 read as zero, and writes to them change nothing.
- R3: Control bit 0 selects the pointer on `addr_out`: 0 picks pointer A and 1 picks pointer B.
- R4: When control bit 2 (auto-update) is 1, each accepted `move_done` steps the active pointer by one. Pointer A uses direction bit 3 and pointer B uses bit 4: 0 means increment and 1 means decrement. The inactive pointer is unchanged.
- R5: When control bit 5 (toggle) is 1, each accepted `move_done` inverts the select bit. If auto-update is also on, the pointer that was active before the move is the one stepped, and the flip happens in the same cycle.
- R6: Increment and decrement wrap modulo 65536: FFFFh+1 gives 0000h and 0000h−1 gives FFFFh.
- R7: An accepted `inc_strobe` adds one to the active pointer, whatever the auto-update and direction bits say, and it never changes the select bit.
- R8: A `move_done` with auto-update and toggle both off changes neither pointer nor the select bit.
- R9: In a cycle with `reg_wr` high, `move_done` and `inc_strobe` are ignored and only the write takes effect. When `move_done` and `inc_strobe` are both high, the increment strobe is ignored.
- R10: Every register update appears on `addr_out` and `reg_rdata` in the cycle after the clock edge that captured it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte (combinational) |
| move_done | input | 1 | A pointer-based data move finished this cycle |
| inc_strobe | input | 1 | Explicit increment of the active pointer |
| addr_out | output | 16 | Active pointer, used as the external data address |

## Verification
Every stimulus is captured at one rising edge, so its effect on `addr_out` is due exactly one cycle later. The bench's driver applies inputs on the falling edge and queues the address a reference model predicts. The monitor pops that entry just after the next rising edge and compares it. Register reads are combinational, so the bench checks them within the same half cycle in which it sets `reg_addr`. Because every queued entry is checked one edge after its stimulus, a result that arrives one cycle early or late is reported as a mismatch.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int CB_SEL    = 0;
  localparam int CB_AUTO   = 2;
  localparam int CB_DIR_A  = 3;
  localparam int CB_DIR_B  = 4;
  localparam int CB_TOGGLE = 5;

  typedef enum logic [2:0] {
    RA_A_LO = 3'd0,
    RA_A_HI = 3'd1,
    RA_B_LO = 3'd2,
    RA_B_HI = 3'd3,
    RA_CTRL = 3'd4
  } reg_idx_e;

  typedef struct packed {
    logic toggle_en;
    logic dir_b;
    logic dir_a;
    logic auto_en;
    logic sel;
  } ctrl_t;

  function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
    logic [7:0] b;
    b = '0;
    b[CB_SEL]    = c.sel;
    b[CB_AUTO]   = c.auto_en;
    b[CB_DIR_A]  = c.dir_a;
    b[CB_DIR_B]  = c.dir_b;
    b[CB_TOGGLE] = c.toggle_en;
    return b;
  endfunction

  function automatic ctrl_t byte_to_ctrl(input logic [7:0] b);
    ctrl_t c;
    c.sel       = b[CB_SEL];
    c.auto_en   = b[CB_AUTO];
    c.dir_a     = b[CB_DIR_A];
    c.dir_b     = b[CB_DIR_B];
    c.toggle_en = b[CB_TOGGLE];
    return c;
  endfunction
endpackage

// File: rtl/dptr_ctrl_reg.sv
module dptr_ctrl_reg
  import dptr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       flip_sel,
  output ctrl_t      ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= byte_to_ctrl(wdata);
    end else if (flip_sel) begin
      ctrl_q.sel <= ~ctrl_q.sel;
    end
  end
endmodule

// File: rtl/dptr_ptr_reg.sv
module dptr_ptr_reg #(
  parameter int DATA_W = 8,
  localparam int PTR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic              step_en,
  input  logic              step_down,
  output logic [PTR_W-1:0]  ptr_q
);
  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] v, input logic down);
    return down ? PTR_W'(v - 1'b1) : PTR_W'(v + 1'b1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (wr_lo) begin
      ptr_q[DATA_W-1:0] <= wdata;
    end else if (wr_hi) begin
      ptr_q[PTR_W-1:DATA_W] <= wdata;
    end else if (step_en) begin
      ptr_q <= step_ptr(ptr_q, step_down);
    end
  end
endmodule

// File: rtl/dptr_rd_mux.sv
module dptr_rd_mux
  import dptr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_PTR = 2,
  localparam int PTR_W = 2 * DATA_W
) (
  input  logic [2:0]             rd_addr,
  input  logic [PTR_W-1:0]       ptrs [NUM_PTR],
  input  ctrl_t                  ctrl,
  output logic [DATA_W-1:0]      rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (rd_addr == 3'(2 * i))     rdata = ptrs[i][DATA_W-1:0];
      if (rd_addr == 3'(2 * i + 1)) rdata = ptrs[i][PTR_W-1:DATA_W];
    end
    if (rd_addr == RA_CTRL) rdata = DATA_W'(ctrl_to_byte(ctrl));
  end
endmodule

// File: rtl/dptr_pair_unit.sv
module dptr_pair_unit
  import dptr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int PTR_W = 2 * DATA_W,
  localparam int NUM_PTR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              move_done,
  input  logic              inc_strobe,
  output logic [PTR_W-1:0]  addr_out
);
  ctrl_t              ctrl_q;
  logic [PTR_W-1:0]   ptrs [NUM_PTR];
  logic [NUM_PTR-1:0] step_en;
  logic [NUM_PTR-1:0] dir_bits;
  logic               move_evt;
  logic               inc_evt;
  logic               flip_evt;
  logic               act_dir;

  assign move_evt = move_done & ~reg_wr;
  assign inc_evt  = inc_strobe & ~reg_wr & ~move_done;
  assign flip_evt = move_evt & ctrl_q.toggle_en;
  assign dir_bits = {ctrl_q.dir_b, ctrl_q.dir_a};
  assign act_dir  = dir_bits[ctrl_q.sel];

  dptr_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr && reg_addr == RA_CTRL),
    .wdata    (reg_wdata[7:0]),
    .flip_sel (flip_evt),
    .ctrl_q   (ctrl_q)
  );

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    assign step_en[g] = (ctrl_q.sel == 1'(g)) &&
                        ((move_evt && ctrl_q.auto_en) || inc_evt);
    dptr_ptr_reg #(.DATA_W(DATA_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_lo     (reg_wr && reg_addr == 3'(2 * g)),
      .wr_hi     (reg_wr && reg_addr == 3'(2 * g + 1)),
      .wdata     (reg_wdata),
      .step_en   (step_en[g]),
      .step_down (move_evt && dir_bits[g]),
      .ptr_q     (ptrs[g])
    );
  end

  dptr_rd_mux #(.DATA_W(DATA_W), .NUM_PTR(NUM_PTR)) u_rd (
    .rd_addr (reg_addr),
    .ptrs    (ptrs),
    .ctrl    (ctrl_q),
    .rdata   (reg_rdata)
  );

  assign addr_out = ptrs[ctrl_q.sel];
endmodule

// File: rtl/dptr_pair_unit_chk.sv
module dptr_pair_unit_chk #(
  parameter int PTR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic             move_done,
  input logic             inc_strobe,
  input logic [PTR_W-1:0] addr_out,
  input logic             sel,
  input logic             auto_en,
  input logic             toggle_en,
  input logic             act_dir,
  input logic [1:0]       step_en
);
  AST_STEP_ONE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_en)); // R4

  AST_AUTO_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && move_done && auto_en && !toggle_en && !act_dir)
    |=> addr_out == PTR_W'($past(addr_out) + 1'b1)); // R4

  AST_AUTO_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && move_done && auto_en && !toggle_en && act_dir)
    |=> addr_out == PTR_W'($past(addr_out) - 1'b1)); // R6

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && move_done && toggle_en) |=> sel != $past(sel)); // R5

  AST_INC_NO_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && inc_strobe && !move_done)
    |=> (sel == $past(sel)) && addr_out == PTR_W'($past(addr_out) + 1'b1)); // R7

  AST_PLAIN_MOVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && move_done && !auto_en && !toggle_en)
    |=> $stable(addr_out) && $stable(sel)); // R8

  AST_WRITE_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr != 3'd4) |=> $stable(sel)); // R9
endmodule

bind dptr_pair_unit dptr_pair_unit_chk #(.PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .move_done  (move_done),
  .inc_strobe (inc_strobe),
  .addr_out   (addr_out),
  .sel        (ctrl_q.sel),
  .auto_en    (ctrl_q.auto_en),
  .toggle_en  (ctrl_q.toggle_en),
  .act_dir    (act_dir),
  .step_en    (step_en)
);

// File: tb/dptr_pair_unit_test.sv
`timescale 1ns/1ps
module dptr_pair_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        move_done = 1'b0;
  logic        inc_strobe = 1'b0;
  logic [15:0] addr_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct { logic [15:0] exp_addr; string req; } exp_item_t;
  exp_item_t sb_q[$];

  // reference state
  logic [15:0] m_ptr [2];
  logic [7:0]  m_ctl;

  always #2.5 clk = ~clk;

  dptr_pair_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .move_done(move_done),
    .inc_strobe(inc_strobe), .addr_out(addr_out)
  );

  function automatic logic [15:0] m_active();
    return m_ptr[m_ctl[0]];
  endfunction

  task automatic model_step(input bit wr, input logic [2:0] a, input logic [7:0] d,
                            input bit mv, input bit inc);
    int s;
    s = m_ctl[0];
    if (wr) begin
      case (a)
        3'd0: m_ptr[0] = {m_ptr[0][15:8], d};
        3'd1: m_ptr[0] = {d, m_ptr[0][7:0]};
        3'd2: m_ptr[1] = {m_ptr[1][15:8], d};
        3'd3: m_ptr[1] = {d, m_ptr[1][7:0]};
        3'd4: m_ctl = d & 8'h3D;
        default: ;
      endcase
    end else if (mv) begin
      if (m_ctl[2]) m_ptr[s] = m_ctl[3 + s] ? m_ptr[s] + 16'hFFFF : m_ptr[s] + 16'd1;
      if (m_ctl[5]) m_ctl[0] = ~m_ctl[0];
    end else if (inc) begin
      m_ptr[s] = m_ptr[s] + 16'd1;
    end
  endtask

  // driver: one cycle of stimulus, pushes expected address
  task automatic drive(input bit wr, input logic [2:0] a, input logic [7:0] d,
                       input bit mv, input bit inc, input string req);
    exp_item_t it;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; move_done = mv; inc_strobe = inc;
    model_step(wr, a, d, mv, inc);
    it.exp_addr = m_active();
    it.req = req;
    sb_q.push_back(it);
    @(negedge clk);
    reg_wr = 1'b0; move_done = 1'b0; inc_strobe = 1'b0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d, input string req);
    drive(1'b1, a, d, 1'b0, 1'b0, req);
  endtask

  task automatic check_read(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      failures++;
      $display("FAIL %s read addr %0d: actual=%h expected=%h", req, a, reg_rdata, exp);
    end
  endtask

  // monitor: compare just after the edge that captured the stimulus (R10)
  always @(posedge clk) begin
    #1;
    if (rst_n && sb_q.size() > 0) begin
      exp_item_t it;
      it = sb_q.pop_front();
      checks++;
      if (addr_out !== it.exp_addr) begin
        failures++;
        $display("FAIL %s addr_out: actual=%h expected=%h", it.req, addr_out, it.exp_addr);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_ptr[0] = '0; m_ptr[1] = '0; m_ctl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1; checks++;
    if (addr_out !== 16'h0) begin
      failures++;
      $display("FAIL R1 addr_out: actual=%h expected=0000", addr_out);
    end
    for (int i = 0; i < 5; i++) check_read(3'(i), 8'h00, "R1");

    // R2 / R3 register map and select
    wr_reg(3'd0, 8'h34, "R2");
    wr_reg(3'd1, 8'h12, "R2");
    wr_reg(3'd2, 8'hCD, "R2");
    wr_reg(3'd3, 8'hAB, "R2");
    check_read(3'd0, 8'h34, "R2");
    check_read(3'd1, 8'h12, "R2");
    check_read(3'd2, 8'hCD, "R2");
    check_read(3'd3, 8'hAB, "R2");
    wr_reg(3'd4, 8'h01, "R3");
    wr_reg(3'd4, 8'h00, "R3");
    wr_reg(3'd4, 8'hFF, "R2");
    check_read(3'd4, 8'h3D, "R2");
    wr_reg(3'd5, 8'h77, "R2");
    check_read(3'd5, 8'h00, "R2");
    check_read(3'd4, 8'h3D, "R2");
    check_read(3'd2, 8'hCD, "R2");

    // R4 auto-update up and down
    wr_reg(3'd4, 8'h04, "R4");
    drive(1'b0, 3'd0, 8'h0, 1'b1, 1'b0, "R4");
    drive(1'b0, 3'd0, 8'h0, 1'b1, 1'b0, "R4");
    wr_reg(3'd4, 8'h0C, "R4");
    drive(1'b0, 3'd0, 8'h0, 1'b1, 1'b0, "R4");
    wr_reg(3'd4, 8'h15, "R4");
    drive(1'b0, 3'd0, 8'h0, 1'b1, 1'b0, "R4");
    check_read(3'd0, 8'h35, "R4");

    // R5 toggle, with and without auto-update
    wr_reg(3'd4, 8'h24, "R5");
    for (int k = 0; k < 4; k++) drive(1'b0, 3'd0, 8'h0, 1'b1, 1'b0, "R5");
    wr_reg(3'd4, 8'h20, "R5");
    drive(1'b0, 3'd0, 8'h0, 1'b1, 1'b0, "R5");
    drive(1'b0, 3'd0, 8'h0, 1'b1, 1'b0, "R5");
    check_read(3'd4, 8'h20, "R5");

    // R6 wrap both directions
    wr_reg(3'd4, 8'h04, "R6");
    wr_reg(3'd0, 8'hFF, "R6");
    wr_reg(3'd1, 8'hFF, "R6");
    drive(1'b0, 3'd0, 8'h0, 1'b1, 1'b0, "R6");
    wr_reg(3'd2, 8'h00, "R6");
    wr_reg(3'd3, 8'h00, "R6");
    wr_reg(3'd4, 8'h15, "R6");
    drive(1'b0, 3'd0, 8'h0, 1'b1, 1'b0, "R6");

    // R7 explicit increment ignores direction, auto-update and toggle
    wr_reg(3'd4, 8'h39, "R7");
    drive(1'b0, 3'd0, 8'h0, 1'b0, 1'b1, "R7");
    drive(1'b0, 3'd0, 8'h0, 1'b0, 1'b1, "R7");
    check_read(3'd4, 8'h39, "R7");
    wr_reg(3'd4, 8'h00, "R7");
    drive(1'b0, 3'd0, 8'h0, 1'b0, 1'b1, "R7");

    // R8 plain move changes nothing
    wr_reg(3'd4, 8'h18, "R8");
    drive(1'b0, 3'd0, 8'h0, 1'b1, 1'b0, "R8");
    check_read(3'd4, 8'h18, "R8");
    check_read(3'd0, 8'h01, "R8");

    // R9 write beats strobes; move beats increment
    wr_reg(3'd4, 8'h24, "R9");
    drive(1'b1, 3'd2, 8'h55, 1'b1, 1'b1, "R9");
    check_read(3'd4, 8'h24, "R9");
    check_read(3'd2, 8'h55, "R9");
    wr_reg(3'd4, 8'h00, "R9");
    drive(1'b0, 3'd0, 8'h0, 1'b1, 1'b1, "R9");
    check_read(3'd0, 8'h01, "R9");
    wr_reg(3'd4, 8'h04, "R9");
    drive(1'b0, 3'd0, 8'h0, 1'b1, 1'b1, "R9");
    check_read(3'd0, 8'h02, "R9");

    repeat (3) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL R10 queue: actual=%0d expected=0", sb_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule